// File: doc/BRIEF.md
# Inbound PCIe Address Window Translator

This block sits on the inbound memory-request path of a PCIe root port, between the point where request addresses have been extracted and the system memory fabric. Every address a bus master presents is tested against one aligned window whose size is a power of two, from 8 MiB to 1 GiB. Addresses inside the window are forwarded with a new system address. Addresses outside it are dropped, and the drop is reported with a pulse and counted.

The window is cut into eight equal slices. Each slice has its own system base, so eight scattered system areas of equal size can be exposed to bus masters. A small register port holds the control word, the window base and the eight slice bases, and it reads back the drop count. Configuration writes go into a staging copy. That copy becomes active only when no translated request is waiting at the output, so a request is never translated with a mix of old and new settings.

Top module: `pcie_inbound_xlate`

## Requirements
- R1: After reset the window is disabled, `out_valid` and `rej_pulse` are low, and the drop count reads 0. While the window is disabled, every accepted request is rejected.
- R2: Register address 0 is the control word: bit 0 enables the window, and bits [3:1] hold the size code c. The window then spans 2^(23+c) bytes.
- R3: An accepted request is a hit only when its address bits at and above position 23+c equal the same bits of the window base (register address 1). Window base bits below 23+c are ignored.
- R4: The slice index of a hit is taken from address bits [22+c:20+c].
- R5: A hit produces `out_addr` = (remap field of the slice << 20) | (the low 20+c bits of the request address). The remap field for slice r sits at register address 8+r, in data bits [SYS_W-21:0], and holds system address bits [SYS_W-1:20].
- R6: A miss produces no output. Instead, `rej_pulse` is high for exactly the cycle after the request was accepted.
- R7: Each miss raises the drop count by one. The count stops at 2^CNT_W-1. It is read at register address 2.
- R8: While `out_valid` is high and `out_ready` is low, `out_addr` stays constant and `req_ready` is low.
- R9: A configuration write holds `req_ready` low until the output stage is empty and the new value has been applied. The next accepted request uses the new value.
- R10: `reg_rdata` returns the register selected by `reg_addr` one cycle later. Addresses 0, 1 and 8 to 15 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Inbound request address valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | PCI memory address of the request |
| out_valid | output | 1 | Translated address valid |
| out_ready | input | 1 | Downstream takes the translated address |
| out_addr | output | SYS_W | Translated system address |
| rej_pulse | output | 1 | One-cycle drop indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The two functions that can collide are a configuration write and a translated result that is still stalled at the output. The bench holds `out_ready` low after a hit and rewrites that slice's remap base while the result waits. It then checks that the waiting address does not change and that no new request is taken. After `out_ready` is released, it sends the same request address again and expects the new translation. Around this case, every size code is swept over all eight slices, using addresses at the slice start, middle and end plus addresses just outside the window.

// File: rtl/pib_pkg.sv
package pib_pkg;
  localparam int SLICE_BITS   = 3;
  localparam int NUM_SLICES   = 1 << SLICE_BITS;
  localparam int WIN_LOG_MIN  = 23;
  localparam int SLICE_FLOOR  = WIN_LOG_MIN - SLICE_BITS;
  localparam int CODE_W       = 3;

  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_WBASE = 4'd1;
  localparam logic [3:0] RA_DROPS = 4'd2;
endpackage

// File: rtl/pib_cfg_regs.sv
module pib_cfg_regs
  import pib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYS_W  = 40,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int RB_W  = SYS_W - SLICE_FLOOR
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [3:0]                        reg_sel,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [DATA_W-1:0]                 rd_data,
  input  logic [CNT_W-1:0]                  drop_cnt,
  input  logic                              pipe_idle,
  output logic                              cfg_busy,
  output logic                              act_en,
  output logic [CODE_W-1:0]                 act_code,
  output logic [ADDR_W-1:0]                 act_base,
  output logic [NUM_SLICES-1:0][RB_W-1:0]   act_remap
);
  logic                             stg_en;
  logic [CODE_W-1:0]                stg_code;
  logic [ADDR_W-1:0]                stg_base;
  logic [NUM_SLICES-1:0][RB_W-1:0]  stg_remap;
  logic                             commit;
  logic                             cfg_write;
  logic [DATA_W-1:0]                rd_next;

  assign cfg_write = wr_en && (reg_sel != RA_DROPS);
  assign commit    = cfg_busy && pipe_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_en   <= 1'b0;
      stg_code <= '0;
      stg_base <= '0;
      act_en   <= 1'b0;
      act_code <= '0;
      act_base <= '0;
      cfg_busy <= 1'b0;
    end else begin
      if (wr_en && reg_sel == RA_CTRL) begin
        stg_en   <= wr_data[0];
        stg_code <= wr_data[CODE_W:1];
      end
      if (wr_en && reg_sel == RA_WBASE) stg_base <= wr_data[ADDR_W-1:0];
      if (commit) begin
        act_en   <= stg_en;
        act_code <= stg_code;
        act_base <= stg_base;
      end
      if (cfg_write)   cfg_busy <= 1'b1;
      else if (commit) cfg_busy <= 1'b0;
    end
  end

  for (genvar r = 0; r < NUM_SLICES; r++) begin : g_slice
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_remap[r] <= '0;
        act_remap[r] <= '0;
      end else begin
        if (wr_en && reg_sel == {1'b1, 3'(r)}) stg_remap[r] <= wr_data[RB_W-1:0];
        if (commit) act_remap[r] <= stg_remap[r];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (reg_sel[3]) begin
      rd_next = DATA_W'(stg_remap[reg_sel[2:0]]);
    end else begin
      case (reg_sel)
        RA_CTRL:  rd_next = DATA_W'({stg_code, stg_en});
        RA_WBASE: rd_next = DATA_W'(stg_base);
        RA_DROPS: rd_next = DATA_W'(drop_cnt);
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_ACTIVE_FROZEN_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    !pipe_idle |=> ($stable(act_base) && $stable(act_code) && $stable(act_en) && $stable(act_remap))) else $error("active config changed while output held"); // R9
  AST_WRITE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    cfg_write |=> cfg_busy) else $error("write did not mark config busy"); // R9
endmodule

// File: rtl/pib_window_decode.sv
module pib_window_decode
  import pib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYS_W  = 40,
  localparam int RB_W  = SYS_W - SLICE_FLOOR
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              win_en,
  input  logic [CODE_W-1:0]                 win_code,
  input  logic [ADDR_W-1:0]                 win_base,
  input  logic [NUM_SLICES-1:0][RB_W-1:0]   remap,
  output logic                              hit,
  output logic [SYS_W-1:0]                  sys_addr
);
  int                     win_log;
  int                     slice_log;
  logic [ADDR_W-1:0]      hi_mask;
  logic [ADDR_W-1:0]      lo_mask;
  logic [ADDR_W-1:0]      shifted;
  logic [SLICE_BITS-1:0]  slice;
  logic [ADDR_W-1:0]      offset;

  always_comb begin
    win_log   = WIN_LOG_MIN + int'(win_code);
    slice_log = win_log - SLICE_BITS;
    hi_mask   = {ADDR_W{1'b1}} << win_log;
    lo_mask   = ~({ADDR_W{1'b1}} << slice_log);
    hit       = win_en && (((addr ^ win_base) & hi_mask) == '0);
    shifted   = addr >> slice_log;
    slice     = shifted[SLICE_BITS-1:0];
    offset    = addr & lo_mask;
    sys_addr  = {remap[slice], {SLICE_FLOOR{1'b0}}} | SYS_W'(offset);
  end
endmodule

// File: rtl/pcie_inbound_xlate.sv
module pcie_inbound_xlate
  import pib_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYS_W  = 40,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int RB_W  = SYS_W - SLICE_FLOOR,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYS_W-1:0]  out_addr,
  output logic              rej_pulse,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic                             cfg_busy;
  logic                             act_en;
  logic [CODE_W-1:0]                act_code;
  logic [ADDR_W-1:0]                act_base;
  logic [NUM_SLICES-1:0][RB_W-1:0]  act_remap;
  logic                             hit;
  logic [SYS_W-1:0]                 xl_addr;
  logic                             accept;
  logic [CNT_W-1:0]                 drop_cnt;

  pib_cfg_regs #(.ADDR_W(ADDR_W), .SYS_W(SYS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_we), .reg_sel(reg_addr), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .drop_cnt(drop_cnt), .pipe_idle(!out_valid), .cfg_busy(cfg_busy),
    .act_en(act_en), .act_code(act_code), .act_base(act_base), .act_remap(act_remap)
  );

  pib_window_decode #(.ADDR_W(ADDR_W), .SYS_W(SYS_W)) u_dec (
    .addr(req_addr), .win_en(act_en), .win_code(act_code), .win_base(act_base),
    .remap(act_remap), .hit(hit), .sys_addr(xl_addr)
  );

  assign req_ready = !cfg_busy && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      rej_pulse <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      if (accept && hit) begin
        out_valid <= 1'b1;
        out_addr  <= xl_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      rej_pulse <= accept && !hit;
      if (accept && !hit && drop_cnt != CNT_MAX) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))) else $error("output changed while stalled"); // R8
  AST_NO_TAKE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !req_ready) else $error("request taken while output held"); // R8
  AST_REJ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |-> $past(req_valid && req_ready)) else $error("reject without request"); // R6
  AST_REJ_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |-> !$rose(out_valid)) else $error("rejected request forwarded"); // R6
  AST_DISABLED_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(act_en)) else $error("output while window disabled"); // R1
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt == CNT_MAX) |=> (drop_cnt == CNT_MAX)) else $error("drop count wrapped"); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> !req_ready) else $error("request taken during config update"); // R9
endmodule

// File: tb/tb_pcie_inbound_xlate.sv
module tb_pcie_inbound_xlate;
  localparam int ADDR_W = 32;
  localparam int SYS_W  = 40;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [SYS_W-1:0]  out_addr;
  logic              rej_pulse;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  int exp_drops = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcie_inbound_xlate #(.ADDR_W(ADDR_W), .SYS_W(SYS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .rej_pulse(rej_pulse),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata == exp, req, longint'(reg_rdata), longint'(exp));
  endtask

  function automatic longint xl(input longint addr, input int code, input longint field);
    longint mask;
    mask = (longint'(1) << (20 + code)) - 1;
    return (field << 20) | (addr & mask);
  endfunction

  task automatic send(input logic [31:0] a, input bit exp_hit, input longint exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      check(out_valid && !rej_pulse && longint'(out_addr) == exp, req, longint'(out_addr), exp);
    end else begin
      check(!out_valid && rej_pulse, req, longint'({out_valid, rej_pulse}), 64'h1);
      if (exp_drops < 255) exp_drops++;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint base;
    longint e1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!out_valid && !rej_pulse, "R1 outputs idle", longint'({out_valid, rej_pulse}), 0);
    rd_check(4'd2, 32'd0, "R1 drop count zero");
    rd_check(4'd0, 32'd0, "R10 control reads zero");
    send(32'h4000_0000, 0, 0, "R1 disabled rejects");
    rd_check(4'd2, 32'(exp_drops), "R7 drop count after first miss");

    base = 64'h4000_0000;
    for (int code = 0; code < 8; code++) begin
      longint win;
      longint sl;
      win = longint'(1) << (23 + code);
      sl  = win >> 3;
      wr(4'd0, 32'((code << 1) | 1));
      wr(4'd1, 32'(base | 64'h123));
      for (int r = 0; r < 8; r++) wr(4'(8 + r), 32'(((r + 1) * 5 + code) << code));
      rd_check(4'd0, 32'((code << 1) | 1), "R10 control readback");
      rd_check(4'd1, 32'(base | 64'h123), "R10 window base readback");
      for (int r = 0; r < 8; r++) begin
        longint f;
        longint a0;
        f  = longint'(((r + 1) * 5 + code) << code);
        a0 = base + r * sl;
        send(32'(a0), 1, xl(a0, code, f), "R4 R5 slice start");
        send(32'(a0 + sl / 2 + 64'h1234), 1, xl(a0 + sl / 2 + 64'h1234, code, f), "R5 slice middle");
        send(32'(a0 + sl - 1), 1, xl(a0 + sl - 1, code, f), "R3 R5 slice end");
      end
      send(32'(base - 1), 0, 0, "R3 below window");
      send(32'(base + win), 0, 0, "R3 above window");
      rd_check(4'd2, 32'(exp_drops), "R7 drop count tracks misses");
    end

    // R2 disabling the window
    wr(4'd0, 32'h0);
    send(32'h4000_0000, 0, 0, "R2 enable bit cleared rejects");

    // R8 R9 write while output stalled
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h4000_0000);
    wr(4'd10, 32'h00123);
    out_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4020_0010;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e1 = xl(64'h4020_0010, 0, 64'h123);
    check(out_valid && longint'(out_addr) == e1, "R8 stalled result present", longint'(out_addr), e1);
    wr(4'd10, 32'h00456);
    req_valid = 1'b1; req_addr = 32'h4020_0020;
    repeat (3) begin
      check(!req_ready, "R8 R9 no request taken while held", longint'(req_ready), 0);
      check(out_valid && longint'(out_addr) == e1, "R8 held address stable", longint'(out_addr), e1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R8 output drained", longint'(out_valid), 0);
    send(32'h4020_0010, 1, xl(64'h4020_0010, 0, 64'h456), "R9 new remap applies");
    rd_check(4'd10, 32'h456, "R10 remap readback");

    // R7 saturation
    while (exp_drops < 255) send(32'h1000_0000, 0, 0, "R7 miss before saturation");
    send(32'h1000_0000, 0, 0, "R6 miss at saturation");
    send(32'h1000_0000, 0, 0, "R6 miss past saturation");
    rd_check(4'd2, 32'd255, "R7 drop count saturated");
    @(negedge clk);
    check(!rej_pulse, "R6 pulse lasts one cycle", longint'(rej_pulse), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule